// File: doc/BRIEF.md
# Dual-Plane Nonvolatile Memory Write Controller

This block models an 8192-byte nonvolatile store made of two independent 4096-byte planes, reached over a multiplexed 8-bit address/data bus. The host first presents the low address byte on the shared bus with an address strobe. It then presents the upper five address bits with a data strobe that carries either a read or a write byte. Address bit 12 picks the plane.

Writes are guarded in three ways: a three-byte unlock sequence, a per-1K-block lock register, and a write-control pin. A write that is accepted loads a 32-byte page buffer. When the page closes, the buffer is committed in one timed internal write cycle, which runs for `WR_CYCLES` clocks. During that cycle the busy plane answers reads with a status byte whose bit 6 flips on every read. The other plane keeps answering reads with stored data and never stalls. The host detects the end of the write by polling until bit 6 stops changing and real data comes back.

Read data leaves as a valid-only stream. `rd_vld` is high for exactly one cycle, one clock after each read strobe. There is no ready and no back-pressure, so the host must take the byte in that cycle. Strobes are single-cycle, synchronous pulses.

Top module: `eep_dual_plane_ctrl`

## Requirements
- R1: The full address is {a_hi, latched low byte}. Bit 12 selects the plane (0: 0x0000-0x0FFF, 1: 0x1000-0x1FFF), and a committed byte reads back from its own address in either plane.
- R2: Every read strobe (bus_sel=1, data_strb=1, rd_wr=1) gives rd_vld=1 with the data on ad_out in the next cycle. This includes reads of the idle plane while the other plane is busy, which return stored data.
- R3: A page write is accepted only after the writes 0xAA at 0x1555, 0x55 at 0x0AAA and 0xA0 at 0x1555. Any mismatching write returns the sequencer to idle. Writes without the sequence leave the array unchanged.
- R4: After unlocking, up to 32 bytes sharing address bits 12..5 are collected. A write to a different page closes the page at once and is itself dropped. All collected bytes are committed in one write cycle.
- R5: The page also closes and commits after PAGE_TMO (100) clock cycles with no write byte.
- R6: The sequence 0xAA at 0x1555, 0x55 at 0x0AAA, 0xC0 at 0x1555, followed by any write byte, loads that byte into the lock register. Bit i locks block i, where block = address bits 12..10. The register is 0 after reset.
- R7: A write byte aimed at a locked block is discarded. With all eight bits set, no address can be written.
- R8: A write byte presented with wr_allow=0 is discarded. A lock-load byte presented with wr_allow=0 leaves the lock register unchanged.
- R9: While a plane is busy, a read from that plane returns {~L[7], T, L[5:0]}, where L is the last byte accepted into the page. T is 0 on the first such read after the commit starts and inverts on each further read. After WR_CYCLES clocks, stored data is returned.
- R10: Write bytes presented while an internal write cycle runs are ignored.
- R11: After reset rd_vld=0 and ad_out=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Chip select, qualifies data strobes |
| addr_strb | input | 1 | Latches ad_in as the low address byte |
| data_strb | input | 1 | One-cycle access strobe |
| rd_wr | input | 1 | 1 = read, 0 = write at data_strb |
| wr_allow | input | 1 | Write control; 0 blocks all write bytes |
| a_hi | input | 5 | Address bits 12..8, sampled at data_strb |
| ad_in | input | 8 | Multiplexed address/data input |
| ad_out | output | 8 | Read data or status byte, 0 when idle |
| rd_vld | output | 1 | Read data valid, no back-pressure |

## Verification
A wrong sequencer or page state shows up as a byte that is missing or unexpectedly present. That becomes visible only after the page timeout plus the full write time, so every write check is followed by a read-back once the cycle has ended. A wrong busy or toggle state is visible at once: the first busy-plane read after a commit must carry an inverted bit 7 and bit 6 at 0, and the next read must flip bit 6. A wrong plane select surfaces as a status byte returned from the idle plane, which is checked within a few cycles of the commit.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ONE, SQ_TWO, SQ_LOCK} seq_st_t;
  typedef enum logic [1:0] {PB_IDLE, PB_WAIT, PB_FILL} pb_st_t;

  localparam logic [7:0]  KEY_B1   = 8'hAA;
  localparam logic [7:0]  KEY_B2   = 8'h55;
  localparam logic [7:0]  OP_PAGE  = 8'hA0;
  localparam logic [7:0]  OP_LOCK  = 8'hC0;
  localparam logic [12:0] KEY_ADR1 = 13'h1555;
  localparam logic [12:0] KEY_ADR2 = 13'h0AAA;
endpackage

// File: rtl/eep_cmd_seq.sv
module eep_cmd_seq
  import eep_pkg::*;
#(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_evt,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_allow,
  output logic          arm_page,
  output logic          lock_we,
  output logic [DW-1:0] lock_val
);
  seq_st_t st;
  logic    at1, at2;

  assign at1 = (wr_addr == AW'(KEY_ADR1));
  assign at2 = (wr_addr == AW'(KEY_ADR2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      arm_page <= 1'b0;
      lock_we  <= 1'b0;
      lock_val <= '0;
    end else begin
      arm_page <= 1'b0;
      lock_we  <= 1'b0;
      if (wr_evt) begin
        case (st)
          SQ_IDLE: st <= (at1 && wr_data == DW'(KEY_B1)) ? SQ_ONE : SQ_IDLE;
          SQ_ONE:  st <= (at2 && wr_data == DW'(KEY_B2)) ? SQ_TWO : SQ_IDLE;
          SQ_TWO: begin
            st <= SQ_IDLE;
            if (at1 && wr_data == DW'(OP_PAGE)) arm_page <= 1'b1;
            else if (at1 && wr_data == DW'(OP_LOCK)) st <= SQ_LOCK;
          end
          default: begin
            lock_we  <= wr_allow;
            lock_val <= wr_data;
            st       <= SQ_IDLE;
          end
        endcase
      end
    end
  end

  // R3
  arm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_page |=> !arm_page);
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf
  import eep_pkg::*;
#(
  parameter int AW  = 13,
  parameter int DW  = 8,
  parameter int PW  = 5,
  parameter int TMO = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             wr_evt,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             byte_ok,
  input  logic             eng_busy,
  output logic             active,
  output logic             commit,
  output logic [AW-PW-1:0] base,
  output logic [(1<<PW)-1:0] vld,
  input  logic [PW-1:0]    rd_idx,
  output logic [DW-1:0]    rd_byte,
  output logic [DW-1:0]    last_byte
);
  localparam int PAGE = 1 << PW;
  localparam int TW   = $clog2(TMO + 1);

  pb_st_t        st;
  logic [TW-1:0] idle_cnt;
  logic [DW-1:0] pg [PAGE];
  logic          store;
  logic [PW-1:0] off;
  logic          same_pg;

  assign off     = wr_addr[PW-1:0];
  assign same_pg = (wr_addr[AW-1:PW] == base);
  assign store   = wr_evt && byte_ok &&
                   ((st == PB_WAIT) || (st == PB_FILL && same_pg));
  assign active  = (st != PB_IDLE);
  assign rd_byte = pg[rd_idx];

  always_ff @(posedge clk) begin
    if (store) pg[off] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= PB_IDLE;
      idle_cnt  <= '0;
      commit    <= 1'b0;
      base      <= '0;
      vld       <= '0;
      last_byte <= '0;
    end else begin
      commit <= 1'b0;
      if (store) last_byte <= wr_data;
      case (st)
        PB_IDLE: begin
          idle_cnt <= '0;
          if (arm) st <= PB_WAIT;
        end
        PB_WAIT: begin
          if (wr_evt) begin
            idle_cnt <= '0;
            if (byte_ok) begin
              base     <= wr_addr[AW-1:PW];
              vld      <= '0;
              vld[off] <= 1'b1;
              st       <= PB_FILL;
            end else begin
              st <= PB_IDLE;
            end
          end else if (idle_cnt == TW'(TMO - 1)) begin
            st <= PB_IDLE;
          end else begin
            idle_cnt <= idle_cnt + 1'b1;
          end
        end
        default: begin
          if (wr_evt) begin
            idle_cnt <= '0;
            if (!same_pg) begin
              commit <= 1'b1;
              st     <= PB_IDLE;
            end else if (byte_ok) begin
              vld[off] <= 1'b1;
            end
          end else if (idle_cnt == TW'(TMO - 1)) begin
            commit <= 1'b1;
            st     <= PB_IDLE;
          end else begin
            idle_cnt <= idle_cnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R5
  tmo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt <= TW'(TMO - 1));
  // R10
  fill_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PB_FILL) |-> !eng_busy);
endmodule

// File: rtl/eep_plane.sv
module eep_plane #(
  parameter int PAW = 12,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           we,
  input  logic [PAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [PAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);
  localparam int DEPTH = 1 << PAW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/eep_dual_plane_ctrl.sv
module eep_dual_plane_ctrl #(
  parameter int AW        = 13,
  parameter int DW        = 8,
  parameter int PW        = 5,
  parameter int BLK_AW    = 10,
  parameter int PAGE_TMO  = 100,
  parameter int WR_CYCLES = 200
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           addr_strb,
  input  logic           data_strb,
  input  logic           rd_wr,
  input  logic           wr_allow,
  input  logic [AW-9:0]  a_hi,
  input  logic [DW-1:0]  ad_in,
  output logic [DW-1:0]  ad_out,
  output logic           rd_vld
);
  localparam int PAW  = AW - 1;
  localparam int PAGE = 1 << PW;
  localparam int NBLK = 1 << (AW - BLK_AW);
  localparam int BW   = AW - PW;
  localparam int CW   = $clog2(WR_CYCLES + 1);

  logic [7:0]      lo_q;
  logic [AW-1:0]   addr;
  logic            wr_evt, rd_evt, seq_evt, byte_ok;
  logic            arm_page, lock_we;
  logic [DW-1:0]   lock_val;
  logic [NBLK-1:0] lock_q;
  logic            pb_active, pb_commit;
  logic [BW-1:0]   pb_base;
  logic [PAGE-1:0] pb_vld;
  logic [DW-1:0]   pb_byte, pb_last;
  logic            busy;
  logic [BW-1:0]   ebase;
  logic [CW-1:0]   ecnt;
  logic [PW-1:0]   eidx;
  logic            we_any;
  logic [1:0]      plane_we;
  logic [DW-1:0]   prd [2];
  logic            tog, stat_q, rplane_q;
  logic [DW-1:0]   stat_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) lo_q <= '0;
    else if (addr_strb) lo_q <= ad_in;
  end

  assign addr    = {a_hi, lo_q};
  assign wr_evt  = bus_sel && data_strb && !rd_wr;
  assign rd_evt  = bus_sel && data_strb && rd_wr;
  assign seq_evt = wr_evt && !pb_active;
  assign byte_ok = wr_allow && !lock_q[addr[AW-1:BLK_AW]] && !busy;

  eep_cmd_seq #(.AW(AW), .DW(DW)) seq_i (
    .clk(clk), .rst_n(rst_n), .wr_evt(seq_evt), .wr_addr(addr),
    .wr_data(ad_in), .wr_allow(wr_allow), .arm_page(arm_page),
    .lock_we(lock_we), .lock_val(lock_val));

  always_ff @(posedge clk) begin
    if (!rst_n) lock_q <= '0;
    else if (lock_we) lock_q <= lock_val[NBLK-1:0];
  end

  eep_page_buf #(.AW(AW), .DW(DW), .PW(PW), .TMO(PAGE_TMO)) pb_i (
    .clk(clk), .rst_n(rst_n), .arm(arm_page), .wr_evt(wr_evt && pb_active),
    .wr_addr(addr), .wr_data(ad_in), .byte_ok(byte_ok), .eng_busy(busy),
    .active(pb_active), .commit(pb_commit), .base(pb_base), .vld(pb_vld),
    .rd_idx(eidx), .rd_byte(pb_byte), .last_byte(pb_last));

  // internal write engine: drains the page one byte per clock, then waits out the cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ebase <= '0;
      ecnt  <= '0;
    end else if (pb_commit) begin
      busy  <= 1'b1;
      ebase <= pb_base;
      ecnt  <= '0;
    end else if (busy) begin
      if (ecnt == CW'(WR_CYCLES - 1)) busy <= 1'b0;
      else ecnt <= ecnt + 1'b1;
    end
  end

  assign eidx   = ecnt[PW-1:0];
  assign we_any = busy && (ecnt < CW'(PAGE)) && pb_vld[eidx];

  for (genvar p = 0; p < 2; p++) begin : g_plane
    assign plane_we[p] = we_any && (ebase[BW-1] == p[0]);
    eep_plane #(.PAW(PAW), .DW(DW)) plane_i (
      .clk(clk), .we(plane_we[p]), .waddr({ebase[BW-2:0], eidx}),
      .wdata(pb_byte), .raddr(addr[PAW-1:0]), .rdata(prd[p]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld    <= 1'b0;
      stat_q    <= 1'b0;
      rplane_q  <= 1'b0;
      tog       <= 1'b0;
      stat_byte <= '0;
    end else begin
      rd_vld <= rd_evt;
      if (pb_commit) tog <= 1'b0;
      if (rd_evt) begin
        rplane_q <= addr[AW-1];
        stat_q   <= busy && (addr[AW-1] == ebase[BW-1]);
        if (busy && (addr[AW-1] == ebase[BW-1])) begin
          stat_byte <= {~pb_last[DW-1], tog, pb_last[DW-3:0]};
          tog       <= ~tog;
        end
      end
    end
  end

  assign ad_out = !rd_vld ? '0 : (stat_q ? stat_byte : prd[rplane_q]);

  // R1
  one_plane_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(plane_we));
  // R10
  no_commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pb_commit);
  // R2
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> $past(bus_sel && data_strb && rd_wr));
  // R9
  stat_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && stat_q) |-> $past(busy));
endmodule

// File: tb/eep_dual_plane_ctrl_tb_top.sv
module eep_dual_plane_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b1, addr_strb = 1'b0, data_strb = 1'b0, rd_wr = 1'b0;
  logic       wr_allow = 1'b1;
  logic [4:0] a_hi = '0;
  logic [7:0] ad_in = '0;
  logic [7:0] ad_out;
  logic       rd_vld;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  eep_dual_plane_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .addr_strb(addr_strb),
    .data_strb(data_strb), .rd_wr(rd_wr), .wr_allow(wr_allow), .a_hi(a_hi),
    .ad_in(ad_in), .ad_out(ad_out), .rd_vld(rd_vld));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); addr_strb = 1'b1; ad_in = a[7:0];
    @(negedge clk); addr_strb = 1'b0; data_strb = 1'b1; rd_wr = 1'b0;
    a_hi = a[12:8]; ad_in = d;
    @(negedge clk); data_strb = 1'b0;
  endtask

  task automatic brd(input logic [12:0] a, output logic [7:0] d, output logic v);
    @(negedge clk); addr_strb = 1'b1; ad_in = a[7:0];
    @(negedge clk); addr_strb = 1'b0; data_strb = 1'b1; rd_wr = 1'b1; a_hi = a[12:8];
    @(negedge clk); data_strb = 1'b0; rd_wr = 1'b0; d = ad_out; v = rd_vld;
  endtask

  task automatic rd_chk(input string tag, input logic [12:0] a, input logic [7:0] exp);
    logic [7:0] d; logic v;
    brd(a, d, v);
    chk({tag, " vld"}, {7'd0, v}, 8'd1);
    chk(tag, d, exp);
  endtask

  task automatic unlock(input logic [7:0] op);
    bwr(13'h1555, 8'hAA); bwr(13'h0AAA, 8'h55); bwr(13'h1555, op);
  endtask

  task automatic settle();
    cyc(110); cyc(230);
  endtask

  function automatic logic [7:0] stat(input logic [7:0] l, input logic t);
    return {~l[7], t, l[5:0]};
  endfunction

  task automatic t_reset();
    chk("R11 vld", {7'd0, rd_vld}, 8'd0);
    chk("R11 data", ad_out, 8'h00);
  endtask

  task automatic t_basic();
    unlock(8'hA0);
    for (int i = 0; i < 4; i++) bwr(13'h0040 + 13'(i), 8'hC0 + 8'(i));
    settle();
    for (int i = 0; i < 4; i++) rd_chk("R1 R5 plane0", 13'h0040 + 13'(i), 8'hC0 + 8'(i));
    unlock(8'hA0);
    bwr(13'h1040, 8'h3C);
    settle();
    rd_chk("R1 plane1", 13'h1040, 8'h3C);
    rd_chk("R1 plane0 kept", 13'h0040, 8'hC0);
  endtask

  task automatic t_timeout();
    unlock(8'hA0);
    bwr(13'h0041, 8'hB1);
    cyc(45);
    rd_chk("R5 before close", 13'h0041, 8'hC1);
    cyc(60);
    rd_chk("R5 after close", 13'h0041, stat(8'hB1, 1'b0));
    cyc(230);
    rd_chk("R5 committed", 13'h0041, 8'hB1);
  endtask

  task automatic t_nounlock();
    bwr(13'h0042, 8'h11);
    settle();
    rd_chk("R3 no seq", 13'h0042, 8'hC2);
    bwr(13'h1555, 8'hAA); bwr(13'h0AAA, 8'h56); bwr(13'h1555, 8'hA0);
    bwr(13'h0043, 8'h22);
    settle();
    rd_chk("R3 bad seq", 13'h0043, 8'hC3);
  endtask

  task automatic t_page();
    unlock(8'hA0);
    for (int i = 0; i < 32; i++) bwr(13'h0100 + 13'(i), 8'(i) ^ 8'h5A);
    bwr(13'h0040, 8'hEE);
    rd_chk("R9 first", 13'h0100, stat(8'd31 ^ 8'h5A, 1'b0));
    rd_chk("R9 second", 13'h011F, stat(8'd31 ^ 8'h5A, 1'b1));
    rd_chk("R2 other plane", 13'h1040, 8'h3C);
    unlock(8'hA0);
    bwr(13'h0101, 8'h00);
    cyc(240);
    for (int i = 0; i < 32; i++) rd_chk("R4 page", 13'h0100 + 13'(i), 8'(i) ^ 8'h5A);
    rd_chk("R4 closing byte dropped", 13'h0040, 8'hC0);
    cyc(110);
    rd_chk("R10 busy write", 13'h0101, 8'h01 ^ 8'h5A);
  endtask

  task automatic t_lock();
    unlock(8'hA0); bwr(13'h0400, 8'h44); settle();
    unlock(8'hA0); bwr(13'h0800, 8'h88); settle();
    unlock(8'hC0); bwr(13'h0000, 8'h02);
    unlock(8'hA0); bwr(13'h0400, 8'h77); settle();
    rd_chk("R7 locked blk1", 13'h0400, 8'h44);
    unlock(8'hA0); bwr(13'h0801, 8'h81); settle();
    rd_chk("R6 blk2 open", 13'h0801, 8'h81);
    unlock(8'hC0); bwr(13'h0000, 8'hFF);
    unlock(8'hA0); bwr(13'h1800, 8'h99); settle();
    unlock(8'hA0); bwr(13'h0800, 8'h99); settle();
    rd_chk("R7 all locked", 13'h0800, 8'h88);
    unlock(8'hC0); bwr(13'h0000, 8'h00);
    unlock(8'hA0); bwr(13'h0400, 8'h45); settle();
    rd_chk("R6 unlocked", 13'h0400, 8'h45);
  endtask

  task automatic t_wc();
    wr_allow = 1'b0;
    unlock(8'hA0); bwr(13'h0800, 8'h12); settle();
    wr_allow = 1'b1;
    rd_chk("R8 wr_allow low", 13'h0800, 8'h88);
    wr_allow = 1'b0;
    unlock(8'hC0); bwr(13'h0000, 8'hFF);
    wr_allow = 1'b1;
    unlock(8'hA0); bwr(13'h0800, 8'h21); settle();
    rd_chk("R8 lock load blocked", 13'h0800, 8'h21);
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_basic();
    t_timeout();
    t_nounlock();
    t_page();
    t_lock();
    t_wc();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule